// File: doc/BRIEF.md
# Message-Signalled Interrupt Forwarding Engine

This block turns interrupt sources that are both enabled and pending into outgoing message requests. Each source from 1 to NSRC-1 holds a pending flag, an enable flag and a 32-bit destination word. The destination word packs a hart index, a guest index and an interrupt identity. A domain-wide enable bit gates every source delivery. When a source is delivered, its pending flag is cleared in the same cycle that its message is loaded into the output register. The message fields are copied from the destination word as it stands at that moment. Source 0 does not exist.

Software drives a single-cycle write port. An operation code selects one of: the domain enable, a destination word, set pending, clear pending, set enable, clear enable, or the generate register. Writing the generate register queues a software message that carries the written hart index and identity with a guest index of zero. Hardware events reach the block as one-cycle trigger pulses, one per source, and each pulse sets that source's pending flag. A read port returns the stored state of any source.

The engine keeps re-evaluating every source after every change, so a register write or a trigger that makes a source ready leads to delivery without any further action. Messages leave on a valid/ready output, at most one per clock.

Top module: `msi_scan_engine`

## Requirements
- R1: While the domain enable (bit 8 of a domain write, op 0) is 0, no source message is issued and pending flags stay set. Once it becomes 1, the waiting sources are delivered.
- R2: A source is delivered only when its pending and enable flags are both 1. Delivery clears pending and leaves enable at 1.
- R3: A message carries hart = destination bits 31:18, guest = bits 17:12 and identity = bits 10:0 of the source's destination word at the time of delivery.
- R4: A destination write (op 1) stores bit 11 as 0 and keeps all other bits.
- R5: When several sources are ready and msg_ready stays high, they are delivered lowest index first, one message per clock, on consecutive cycles.
- R6: While msg_valid is 1 and msg_ready is 0, the message fields hold steady and no further source is taken, so other ready sources stay pending.
- R7: A pulse on src_trig[i] sets pending for source i. If source i is enabled and the domain enable is 1, its message follows without any register write.
- R8: A generate write (op 6) issues a message with hart = data bits 31:18, guest = 0 and identity = data bits 10:0, and stores the data with bits 17:12 cleared. A queued software message wins over a ready source when the output frees.
- R9: Writes to index 0 or to any index of NSRC or above change nothing, and reads there return zeros.
- R10: Clear-pending (op 3) and clear-enable (op 5) clear the addressed flag. Set-pending (op 2) and set-enable (op 4) set it.
- R11: After reset there is no message, and every flag, every destination word and the stored generate value are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_op | input | 3 | Write operation code |
| wr_idx | input | IDX_W | Source index for the write |
| wr_data | input | 32 | Write data |
| src_trig | input | NSRC | Per-source pending-set pulses |
| rd_idx | input | IDX_W | Source index for readback |
| rd_target | output | 32 | Stored destination word of rd_idx |
| rd_pending | output | 1 | Pending flag of rd_idx |
| rd_enabled | output | 1 | Enable flag of rd_idx |
| gen_value | output | 32 | Stored generate value |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Downstream accepts the message |
| msg_hart | output | HART_W | Hart index of the message |
| msg_guest | output | GUEST_W | Guest index of the message |
| msg_eiid | output | EIID_W | Interrupt identity of the message |

## Verification
The bench uses the default build: NSRC = 8, identity width 11, guest width 6 and the lowest-first priority picker. With these values the index port is 4 bits wide, so both index 0 and the out-of-range index 8 can be driven, and a destination word of all ones reaches every field boundary. Seven live sources are enough to place two or three ready sources side by side, which exercises ascending delivery order, stalls under backpressure, and a software message arriving between two source messages.

// File: rtl/msi_fwd_pkg.sv
package msi_fwd_pkg;

   typedef enum logic [2:0] {
      OP_DOMAIN   = 3'd0,
      OP_TARGET   = 3'd1,
      OP_SET_PEND = 3'd2,
      OP_CLR_PEND = 3'd3,
      OP_SET_EN   = 3'd4,
      OP_CLR_EN   = 3'd5,
      OP_GEN      = 3'd6
   } wr_op_e;

   // bit of the domain write that carries the delivery enable
   localparam int IE_BIT    = 8;
   // first bit of the guest field inside a destination word
   localparam int GUEST_LSB = 12;

   // picker variants
   localparam int PICK_LOOP   = 0;
   localparam int PICK_ONEHOT = 1;

endpackage

// File: rtl/msi_src_bank.sv
module msi_src_bank
   import msi_fwd_pkg::*;
#(
   parameter int          NSRC     = 8,
   parameter int          IDX_W    = 4,
   parameter logic [31:0] TGT_MASK = 32'hFFFF_F7FF
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [2:0]             wr_op,
   input  logic [IDX_W-1:0]       wr_idx,
   input  logic [31:0]            wr_data,
   input  logic [NSRC-1:0]        trig,
   input  logic                   clr_vld,
   input  logic [IDX_W-1:0]       clr_idx,
   output logic [NSRC-1:0]        pend_vec,
   output logic [NSRC-1:0]        en_vec,
   output logic [NSRC-1:0][31:0]  tgt_vec
);

   wr_op_e op;
   assign op = wr_op_e'(wr_op);

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (i == 0) begin : g_absent
         assign pend_vec[i] = 1'b0;
         assign en_vec[i]   = 1'b0;
         assign tgt_vec[i]  = '0;
      end else begin : g_live
         logic        sel;
         logic        taken;
         logic        pend_r;
         logic        en_r;
         logic [31:0] tgt_r;

         assign sel   = wr_en && (wr_idx == IDX_W'(i));
         assign taken = clr_vld && (clr_idx == IDX_W'(i));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pend_r <= 1'b0;
               en_r   <= 1'b0;
               tgt_r  <= '0;
            end else begin
               // a new event wins over a clear in the same cycle
               if ((sel && op == OP_SET_PEND) || trig[i])
                  pend_r <= 1'b1;
               else if ((sel && op == OP_CLR_PEND) || taken)
                  pend_r <= 1'b0;

               if (sel && op == OP_SET_EN)
                  en_r <= 1'b1;
               else if (sel && op == OP_CLR_EN)
                  en_r <= 1'b0;

               if (sel && op == OP_TARGET)
                  tgt_r <= wr_data & TGT_MASK;
            end
         end

         assign pend_vec[i] = pend_r;
         assign en_vec[i]   = en_r;
         assign tgt_vec[i]  = tgt_r;
      end
   end

endmodule

// File: rtl/msi_pick.sv
module msi_pick
   import msi_fwd_pkg::*;
#(
   parameter int NSRC    = 8,
   parameter int IDX_W   = 4,
   parameter int VARIANT = PICK_ONEHOT
) (
   input  logic [NSRC-1:0]  req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);

   assign found = |req;

   if (VARIANT == PICK_LOOP) begin : g_loop
      // walk downward so that the lowest set bit is the last one written
      always_comb begin
         idx = '0;
         for (int k = NSRC - 1; k >= 0; k--) begin
            if (req[k]) idx = IDX_W'(k);
         end
      end
   end else begin : g_onehot
      // isolate the lowest set bit, then encode it
      logic [NSRC-1:0] low_oh;
      assign low_oh = req & (~req + NSRC'(1));

      always_comb begin
         idx = '0;
         for (int k = 0; k < NSRC; k++) begin
            if (low_oh[k]) idx = idx | IDX_W'(k);
         end
      end
   end

endmodule

// File: rtl/msi_out_stage.sv
module msi_out_stage #(
   parameter int HART_W  = 14,
   parameter int GUEST_W = 6,
   parameter int EIID_W  = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               gen_vld,
   input  logic [HART_W-1:0]  gen_hart,
   input  logic [EIID_W-1:0]  gen_eiid,
   input  logic               src_vld,
   input  logic [HART_W-1:0]  src_hart,
   input  logic [GUEST_W-1:0] src_guest,
   input  logic [EIID_W-1:0]  src_eiid,
   output logic               gen_take,
   output logic               src_take,
   output logic               msg_valid,
   input  logic               msg_ready,
   output logic [HART_W-1:0]  msg_hart,
   output logic [GUEST_W-1:0] msg_guest,
   output logic [EIID_W-1:0]  msg_eiid
);

   logic slot_free;

   assign slot_free = !msg_valid || msg_ready;
   assign gen_take  = slot_free && gen_vld;
   assign src_take  = slot_free && !gen_vld && src_vld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
         msg_hart  <= '0;
         msg_guest <= '0;
         msg_eiid  <= '0;
      end else if (gen_take) begin
         msg_valid <= 1'b1;
         msg_hart  <= gen_hart;
         msg_guest <= '0;
         msg_eiid  <= gen_eiid;
      end else if (src_take) begin
         msg_valid <= 1'b1;
         msg_hart  <= src_hart;
         msg_guest <= src_guest;
         msg_eiid  <= src_eiid;
      end else if (msg_ready) begin
         msg_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/msi_scan_engine.sv
module msi_scan_engine
   import msi_fwd_pkg::*;
#(
   parameter int NSRC     = 8,
   parameter int EIID_W   = 11,
   parameter int GUEST_W  = 6,
   parameter int PICK_VAR = PICK_ONEHOT,
   localparam int IDX_W    = $clog2(NSRC) + 1,
   localparam int HART_LSB = GUEST_LSB + GUEST_W,
   localparam int HART_W   = 32 - HART_LSB
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [2:0]         wr_op,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [31:0]        wr_data,
   input  logic [NSRC-1:0]    src_trig,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [31:0]        rd_target,
   output logic               rd_pending,
   output logic               rd_enabled,
   output logic [31:0]        gen_value,
   output logic               msg_valid,
   input  logic               msg_ready,
   output logic [HART_W-1:0]  msg_hart,
   output logic [GUEST_W-1:0] msg_guest,
   output logic [EIID_W-1:0]  msg_eiid
);

   localparam logic [31:0] EIID_MASK  = (32'd1 << EIID_W) - 32'd1;
   localparam logic [31:0] GUEST_MASK = ((32'd1 << GUEST_W) - 32'd1) << GUEST_LSB;
   localparam logic [31:0] HART_MASK  = ~((32'd1 << HART_LSB) - 32'd1);
   localparam logic [31:0] TGT_MASK   = EIID_MASK | GUEST_MASK | HART_MASK;

   if (NSRC < 2) begin : g_bad_nsrc
      $error("msi_scan_engine: NSRC must be at least 2");
   end
   if (EIID_W < 1 || EIID_W > GUEST_LSB) begin : g_bad_eiid
      $error("msi_scan_engine: identity field must fit below the guest field");
   end
   if (GUEST_W < 1 || HART_W < 1) begin : g_bad_guest
      $error("msi_scan_engine: guest field leaves no room for the hart field");
   end
   if (PICK_VAR != PICK_LOOP && PICK_VAR != PICK_ONEHOT) begin : g_bad_pick
      $error("msi_scan_engine: unknown picker variant");
   end

   wr_op_e op;
   assign op = wr_op_e'(wr_op);

   // ---------------- domain enable and software message slot ----------------
   logic        ie_q;
   logic        gen_pend_q;
   logic [31:0] gen_val_q;
   logic        gen_take;
   logic        src_take;
   logic        gen_wr;

   assign gen_wr = wr_en && (op == OP_GEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q       <= 1'b0;
         gen_pend_q <= 1'b0;
         gen_val_q  <= '0;
      end else begin
         if (wr_en && op == OP_DOMAIN)
            ie_q <= wr_data[IE_BIT];
         if (gen_wr) begin
            gen_pend_q <= 1'b1;
            gen_val_q  <= wr_data & ~GUEST_MASK;
         end else if (gen_take) begin
            gen_pend_q <= 1'b0;
         end
      end
   end

   assign gen_value = gen_val_q;

   // ---------------- per-source state ----------------
   logic [NSRC-1:0]       pend_vec;
   logic [NSRC-1:0]       en_vec;
   logic [NSRC-1:0][31:0] tgt_vec;
   logic [IDX_W-1:0]      pick_idx;
   logic                  pick_found;

   msi_src_bank #(
      .NSRC     (NSRC),
      .IDX_W    (IDX_W),
      .TGT_MASK (TGT_MASK)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_op    (wr_op),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .trig     (src_trig),
      .clr_vld  (src_take),
      .clr_idx  (pick_idx),
      .pend_vec (pend_vec),
      .en_vec   (en_vec),
      .tgt_vec  (tgt_vec)
   );

   // ---------------- selection ----------------
   logic [NSRC-1:0] ready_vec;
   assign ready_vec = pend_vec & en_vec;

   msi_pick #(
      .NSRC    (NSRC),
      .IDX_W   (IDX_W),
      .VARIANT (PICK_VAR)
   ) u_pick (
      .req   (ready_vec),
      .found (pick_found),
      .idx   (pick_idx)
   );

   logic [31:0] pick_tgt;
   always_comb begin
      pick_tgt = '0;
      for (int k = 0; k < NSRC; k++) begin
         if (pick_idx == IDX_W'(k)) pick_tgt = tgt_vec[k];
      end
   end

   // ---------------- output ----------------
   msi_out_stage #(
      .HART_W  (HART_W),
      .GUEST_W (GUEST_W),
      .EIID_W  (EIID_W)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .gen_vld   (gen_pend_q),
      .gen_hart  (gen_val_q[31:HART_LSB]),
      .gen_eiid  (gen_val_q[EIID_W-1:0]),
      .src_vld   (ie_q && pick_found),
      .src_hart  (pick_tgt[31:HART_LSB]),
      .src_guest (pick_tgt[HART_LSB-1:GUEST_LSB]),
      .src_eiid  (pick_tgt[EIID_W-1:0]),
      .gen_take  (gen_take),
      .src_take  (src_take),
      .msg_valid (msg_valid),
      .msg_ready (msg_ready),
      .msg_hart  (msg_hart),
      .msg_guest (msg_guest),
      .msg_eiid  (msg_eiid)
   );

   // ---------------- readback ----------------
   always_comb begin
      rd_target  = '0;
      rd_pending = 1'b0;
      rd_enabled = 1'b0;
      for (int k = 0; k < NSRC; k++) begin
         if (rd_idx == IDX_W'(k)) begin
            rd_target  = tgt_vec[k];
            rd_pending = pend_vec[k];
            rd_enabled = en_vec[k];
         end
      end
   end

endmodule

// File: rtl/msi_fwd_chk.sv
module msi_fwd_chk #(
   parameter int NSRC    = 8,
   parameter int IDX_W   = 4,
   parameter int HART_W  = 14,
   parameter int GUEST_W = 6,
   parameter int EIID_W  = 11
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ie_q,
   input logic               src_take,
   input logic               gen_take,
   input logic [IDX_W-1:0]   pick_idx,
   input logic [NSRC-1:0]    pend_vec,
   input logic [NSRC-1:0]    en_vec,
   input logic               msg_valid,
   input logic               msg_ready,
   input logic [HART_W-1:0]  msg_hart,
   input logic [GUEST_W-1:0] msg_guest,
   input logic [EIID_W-1:0]  msg_eiid
);

   // R1
   src_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_take |-> ie_q);

   // R2
   src_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_take |-> (pend_vec[pick_idx] && en_vec[pick_idx]));

   // R2
   src_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_take |=> msg_valid);

   // R6
   hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_hart) &&
                                     $stable(msg_guest) && $stable(msg_eiid)));

   // R6
   no_take_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |-> !(src_take || gen_take));

   // R8
   gen_guest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gen_take |=> (msg_valid && msg_guest == '0));

   // R9
   no_zero_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_take |-> (pick_idx != '0));

endmodule

bind msi_scan_engine msi_fwd_chk #(
   .NSRC    (NSRC),
   .IDX_W   (IDX_W),
   .HART_W  (HART_W),
   .GUEST_W (GUEST_W),
   .EIID_W  (EIID_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ie_q      (ie_q),
   .src_take  (src_take),
   .gen_take  (gen_take),
   .pick_idx  (pick_idx),
   .pend_vec  (pend_vec),
   .en_vec    (en_vec),
   .msg_valid (msg_valid),
   .msg_ready (msg_ready),
   .msg_hart  (msg_hart),
   .msg_guest (msg_guest),
   .msg_eiid  (msg_eiid)
);

// File: tb/tb_msi_scan_engine.sv
module tb_msi_scan_engine;

   localparam int NSRC  = 8;
   localparam int IDX_W = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [2:0]       wr_op = '0;
   logic [IDX_W-1:0] wr_idx = '0;
   logic [31:0]      wr_data = '0;
   logic [NSRC-1:0]  src_trig = '0;
   logic [IDX_W-1:0] rd_idx = '0;
   logic [31:0]      rd_target;
   logic             rd_pending;
   logic             rd_enabled;
   logic [31:0]      gen_value;
   logic             msg_valid;
   logic             msg_ready = 1'b1;
   logic [13:0]      msg_hart;
   logic [5:0]       msg_guest;
   logic [10:0]      msg_eiid;

   always #5 clk = ~clk;

   msi_scan_engine dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_op(wr_op), .wr_idx(wr_idx),
      .wr_data(wr_data), .src_trig(src_trig), .rd_idx(rd_idx),
      .rd_target(rd_target), .rd_pending(rd_pending), .rd_enabled(rd_enabled),
      .gen_value(gen_value), .msg_valid(msg_valid), .msg_ready(msg_ready),
      .msg_hart(msg_hart), .msg_guest(msg_guest), .msg_eiid(msg_eiid)
   );

   int          n_tests = 0;
   int          n_fail  = 0;
   int          cyc     = 0;
   logic [31:0] exp_q[$];
   int          hs_q[$];
   bit          done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [31:0] mk(int h, int g, int e);
      return (32'(h) << 18) | (32'(g) << 12) | 32'(e);
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, expv);
      end
   endtask

   // monitor: a handshake seen here completes at the next rising edge
   always @(negedge clk) begin
      if (rst_n && msg_valid && msg_ready) begin
         logic [31:0] got;
         got = {msg_hart, msg_guest, 1'b0, msg_eiid};
         hs_q.push_back(cyc);
         if (exp_q.size() == 0) begin
            check(1'b0, "R1/R2 unexpected message", got, 32'h0);
         end else begin
            logic [31:0] want;
            want = exp_q.pop_front();
            check(got == want, "R3/R5/R8 message fields", got, want);
         end
      end
   end

   task automatic wr(logic [2:0] op, int idx, logic [31:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_op = op; wr_idx = IDX_W'(idx); wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         check(1'b0, "watchdog", 32'(cyc), 32'h0);
         finish_run();
      end
   end

   initial begin
      logic [13:0] h0;
      logic [10:0] e0;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);

      // R11 reset state
      rd_idx = 3; #1;
      check(msg_valid == 0, "R11 msg_valid", 32'(msg_valid), 0);
      check(rd_target == 0 && !rd_pending && !rd_enabled, "R11 source state",
            rd_target, 0);
      check(gen_value == 0, "R11 gen value", gen_value, 0);

      // R4 destination masking
      wr(3'd1, 3, 32'hFFFF_FFFF);
      #1 check(rd_target == 32'hFFFF_F7FF, "R4 target mask", rd_target, 32'hFFFF_F7FF);

      // R1 gating by domain enable
      wr(3'd4, 3, 0);
      wr(3'd2, 3, 0);
      wait_cyc(4);
      check(msg_valid == 0, "R1 no delivery while disabled", 32'(msg_valid), 0);
      check(rd_pending == 1, "R1 pending kept", 32'(rd_pending), 1);
      exp_q.push_back(32'hFFFF_F7FF);
      wr(3'd0, 0, 32'h100);
      wait_cyc(4);
      check(exp_q.size() == 0, "R1 delivered after enable", 32'(exp_q.size()), 0);
      check(rd_pending == 0 && rd_enabled == 1, "R2 pending cleared, enable kept",
            {30'b0, rd_pending, rd_enabled}, 32'h1);

      // R2 pending without enable, R10 clears
      rd_idx = 5;
      wr(3'd1, 5, mk(6, 6, 6));
      wr(3'd2, 5, 0);
      wait_cyc(3);
      check(msg_valid == 0 && rd_pending == 1, "R2 not enabled, no delivery",
            {31'b0, msg_valid}, 0);
      wr(3'd3, 5, 0);
      #1 check(rd_pending == 0, "R10 clear pending", 32'(rd_pending), 0);
      wr(3'd4, 5, 0);
      #1 check(rd_enabled == 1, "R10 set enable", 32'(rd_enabled), 1);
      wr(3'd5, 5, 0);
      #1 check(rd_enabled == 0, "R10 clear enable", 32'(rd_enabled), 0);

      // R5 ascending order, back to back
      wr(3'd0, 0, 0);
      wr(3'd1, 2, mk(1, 2, 'h10));
      wr(3'd1, 4, mk(2, 3, 'h20));
      wr(3'd1, 6, mk(3, 4, 'h30));
      wr(3'd4, 2, 0); wr(3'd4, 4, 0); wr(3'd4, 6, 0);
      wr(3'd2, 6, 0); wr(3'd2, 4, 0); wr(3'd2, 2, 0);
      exp_q.push_back(mk(1, 2, 'h10));
      exp_q.push_back(mk(2, 3, 'h20));
      exp_q.push_back(mk(3, 4, 'h30));
      wr(3'd0, 0, 32'h100);
      wait_cyc(6);
      check(exp_q.size() == 0, "R5 all delivered", 32'(exp_q.size()), 0);
      check(hs_q[$] - hs_q[$-1] == 1 && hs_q[$-1] - hs_q[$-2] == 1,
            "R5 one per clock", 32'(hs_q[$] - hs_q[$-2]), 2);

      // R6 stall
      msg_ready = 1'b0;
      wr(3'd1, 1, mk(7, 1, 'h71));
      wr(3'd1, 7, mk(8, 2, 'h77));
      wr(3'd4, 1, 0); wr(3'd4, 7, 0);
      exp_q.push_back(mk(7, 1, 'h71));
      exp_q.push_back(mk(8, 2, 'h77));
      wr(3'd2, 1, 0);
      wr(3'd2, 7, 0);
      wait_cyc(3);
      rd_idx = 7; #1;
      check(msg_valid == 1 && msg_eiid == 11'h71, "R6 first held", 32'(msg_eiid), 32'h71);
      check(rd_pending == 1, "R6 second stays pending", 32'(rd_pending), 1);
      h0 = msg_hart; e0 = msg_eiid;
      wait_cyc(3);
      check(msg_valid && msg_hart == h0 && msg_eiid == e0, "R6 fields stable",
            32'(msg_hart), 32'(h0));
      msg_ready = 1'b1;
      wait_cyc(4);
      check(exp_q.size() == 0, "R6 drained after release", 32'(exp_q.size()), 0);

      // R7 trigger
      exp_q.push_back(mk(2, 3, 'h20));
      @(posedge clk); #1 src_trig = 8'h10;
      @(posedge clk); #1 src_trig = 8'h00;
      wait_cyc(4);
      check(exp_q.size() == 0, "R7 trigger delivered", 32'(exp_q.size()), 0);
      @(posedge clk); #1 src_trig = 8'h20;
      @(posedge clk); #1 src_trig = 8'h00;
      rd_idx = 5;
      wait_cyc(3);
      check(rd_pending == 1 && msg_valid == 0, "R7 trigger on disabled source",
            32'(rd_pending), 1);

      // R8 software message
      exp_q.push_back(mk(5, 0, 'h123));
      wr(3'd6, 0, mk(5, 'h2A, 'h123));
      wait_cyc(3);
      check(exp_q.size() == 0, "R8 software message", 32'(exp_q.size()), 0);
      check(gen_value == mk(5, 0, 'h123), "R8 stored value", gen_value, mk(5, 0, 'h123));

      // R8 precedence over a waiting source
      msg_ready = 1'b0;
      exp_q.push_back(mk(1, 2, 'h10));
      exp_q.push_back(mk(9, 0, 'h55));
      exp_q.push_back(mk(2, 3, 'h20));
      wr(3'd2, 2, 0);
      wr(3'd2, 4, 0);
      wr(3'd6, 0, mk(9, 7, 'h55));
      wait_cyc(2);
      msg_ready = 1'b1;
      wait_cyc(6);
      check(exp_q.size() == 0, "R8 software message ordering", 32'(exp_q.size()), 0);

      // R9 index 0 and out of range
      wr(3'd1, 0, 32'hFFFF_FFFF); wr(3'd4, 0, 0); wr(3'd2, 0, 0);
      wr(3'd1, 8, 32'hFFFF_FFFF); wr(3'd4, 8, 0); wr(3'd2, 8, 0);
      rd_idx = 0; #1;
      check(rd_target == 0 && !rd_pending && !rd_enabled, "R9 index 0", rd_target, 0);
      rd_idx = 8; #1;
      check(rd_target == 0 && !rd_pending && !rd_enabled, "R9 index 8", rd_target, 0);
      rd_idx = 3; #1;
      check(rd_target == 32'hFFFF_F7FF, "R9 neighbour untouched", rd_target, 32'hFFFF_F7FF);
      wait_cyc(3);
      check(msg_valid == 0 && exp_q.size() == 0, "R9 no message", 32'(msg_valid), 0);

      done = 1'b1;
      finish_run();
   end

endmodule